// File: doc/BRIEF.md
# Stall-Driven Thread Migration Arbiter

This block is the central decision point for a small cluster of multithreaded cores that share an off-core pool of parked thread state. Each core periodically reports counter samples: how many ready instructions could not issue for lack of execution resources, and how many cycles its contexts spent in long-latency memory stalls. The arbiter sums these per core over a programmable window (typically ten thousand cycles) and keeps the last completed window as the core's recent conflict rate and stall rate. Rates stay as raw counts over the window, so every comparison is a compare or a constant multiply and no divider is needed.

When a core reports that a thread has stalled on a long-latency load, the arbiter decides whether to evict that thread to the parked store. Eviction needs three things: the core is running more than just that thread, the core's recent conflict count exceeds a threshold, and a trial run of the placement rule says the thread would land elsewhere. When the load completes, the arbiter picks the destination. The candidate is the core with the highest recent stall rate that has a free context. The thread returns to its previous core unless the candidate beats it by more than five percent.

Events queue in a small FIFO, and only one migration command is outstanding at a time. A command stays asserted until the migration datapath acknowledges it.

Top module: `mig_arbiter`

## Requirements
- R1: Per-core sample sums are taken over windows of `cfg_window` cycles, and every decision uses the sums of the last completed window. A core's conflict count is the window sum of `smp_conf` and its stall count is the window sum of `smp_stall`.
- R2: A stall event (ev_kind=0) leads to an eviction only if the stalled core's conflict count is strictly greater than `cfg_conf_thr`.
- R3: A stall event on a core with fewer than two occupied contexts (bits of `ctx_occ` for core c are `[c*2+1:c*2]`) never produces a command.
- R4: Eviction is suppressed when the placement rule, applied with the stalled core as the previous core and that core counted as free, selects the stalled core itself.
- R5: Placement returns the previous core when it has a free context and the candidate's stall count times 20 is not greater than the previous core's stall count times 21. Otherwise it returns the candidate.
- R6: The candidate is the core with the highest stall count among cores with a free context. On a tie the lowest core index wins.
- R7: A core with both contexts occupied is never a dispatch destination. When the previous core is full, the candidate is used without the margin test.
- R8: A completion for an evicted thread while no core has a free context waits at the queue head. The dispatch is issued once a context frees.
- R9: At most one command is outstanding. `cmd_valid`, `cmd_kind`, `cmd_thread` and `cmd_core` hold steady until `cmd_done`, and queued events are then served in arrival order.
- R10: A completion (ev_kind=1) for a thread that is not parked, or a stall for a thread already parked, produces no command.
- R11: During and right after reset no command is asserted.
- R12: Commands encode eviction as `cmd_kind`=0 (with `cmd_core` the core being vacated) and dispatch as `cmd_kind`=1 (with `cmd_core` the destination).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_window | input | WIN_W | Window length in cycles |
| cfg_conf_thr | input | ACC_W | Conflict count threshold per window |
| smp_valid | input | NCORE | Per-core sample strobe |
| smp_conf | input | NCORE*SMP_W | Per-core blocked-ready-instruction count |
| smp_stall | input | NCORE*SMP_W | Per-core long-latency stall cycle count |
| ctx_occ | input | NCORE*NCTX | Context occupancy, one bit per context |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 1 | 0 = stall, 1 = load completion |
| ev_thread | input | TW | Thread ID of the event |
| ev_core | input | CW | Core of a stall event |
| cmd_valid | output | 1 | Command outstanding |
| cmd_kind | output | 1 | 0 = evict, 1 = dispatch |
| cmd_thread | output | TW | Thread to move |
| cmd_core | output | CW | Core vacated or destination |
| cmd_done | input | 1 | Migration acknowledge |

## Verification
The assertions assume that events are never pushed into a full queue and that the window length and threshold are not changed while the block runs. The bench sets the configuration before releasing reset. It sends at most two events before draining them, and it issues completions only for threads it has seen evicted, so the queue stays well below its depth. Occupancy and sample values are changed only while no command is outstanding, and each change is followed by more than three whole windows, so the recent rates are settled before the next event.

// File: rtl/mig_pkg.sv
package mig_pkg;
  typedef enum logic {EV_STALL = 1'b0, EV_DONE = 1'b1} ev_kind_e;
  typedef enum logic {CMD_EVICT = 1'b0, CMD_DISPATCH = 1'b1} cmd_kind_e;
endpackage

// File: rtl/mig_rate_track.sv
module mig_rate_track #(
  parameter int NCORE = 4,
  parameter int SMP_W = 8,
  parameter int ACC_W = 24,
  parameter int WIN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WIN_W-1:0]       cfg_window,
  input  logic [NCORE-1:0]       smp_valid,
  input  logic [NCORE*SMP_W-1:0] smp_conf,
  input  logic [NCORE*SMP_W-1:0] smp_stall,
  output logic [NCORE*ACC_W-1:0] conf_rate,
  output logic [NCORE*ACC_W-1:0] stall_rate
);
  logic [WIN_W-1:0] win_q, win_d;
  logic             wrap;

  always_comb begin
    wrap  = ((WIN_W+1)'(win_q) + (WIN_W+1)'(1)) >= (WIN_W+1)'(cfg_window);
    win_d = wrap ? '0 : win_q + WIN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    logic [ACC_W-1:0] acc_c_q, acc_s_q, acc_c_d, acc_s_d;
    logic [ACC_W-1:0] rate_c_q, rate_s_q;
    logic [ACC_W-1:0] sum_c, sum_s;

    always_comb begin
      sum_c   = acc_c_q + (smp_valid[i] ? ACC_W'(smp_conf[i*SMP_W +: SMP_W])  : '0);
      sum_s   = acc_s_q + (smp_valid[i] ? ACC_W'(smp_stall[i*SMP_W +: SMP_W]) : '0);
      acc_c_d = wrap ? '0 : sum_c;
      acc_s_d = wrap ? '0 : sum_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_c_q  <= '0;
        acc_s_q  <= '0;
        rate_c_q <= '0;
        rate_s_q <= '0;
      end else begin
        acc_c_q <= acc_c_d;
        acc_s_q <= acc_s_d;
        if (wrap) begin
          rate_c_q <= sum_c;
          rate_s_q <= sum_s;
        end
      end
    end

    assign conf_rate[i*ACC_W +: ACC_W]  = rate_c_q;
    assign stall_rate[i*ACC_W +: ACC_W] = rate_s_q;
  end

  // R1: the window position never passes the programmed length
  a_r1_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_window > WIN_W'(1)) |-> (win_q < cfg_window));
endmodule

// File: rtl/mig_evt_fifo.sv
module mig_evt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [AW-1:0]           wr_q, rd_q, wr_d, rd_d;
  logic [AW:0]             cnt_q, cnt_d;
  logic                    do_push, do_pop;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == (AW+1)'(DEPTH));
    do_push = push && !full;
    do_pop  = pop && !empty;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + AW'(1);
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + AW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + (AW+1)'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - (AW+1)'(1);
    dout = mem_q[rd_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= din;
  end

  // R9: the producer never pushes into a full queue (input assumption)
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  // R9: occupancy stays within the storage
  a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));
endmodule

// File: rtl/mig_place.sv
module mig_place #(
  parameter int NCORE    = 4,
  parameter int ACC_W    = 24,
  parameter int HYST_NUM = 21,
  parameter int HYST_DEN = 20,
  localparam int CW      = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic [NCORE*ACC_W-1:0] stall_rate,
  input  logic [NCORE-1:0]       elig,
  input  logic [CW-1:0]          prev,
  output logic                   found,
  output logic [CW-1:0]          dest
);
  localparam int PW = ACC_W + 8;

  logic [ACC_W-1:0] best, prev_rate;
  logic [CW-1:0]    cand;
  logic [PW-1:0]    lhs, rhs;
  logic             take_cand;

  always_comb begin
    found = 1'b0;
    cand  = '0;
    best  = '0;
    for (int i = 0; i < NCORE; i++) begin
      if (elig[i] && (!found || (stall_rate[i*ACC_W +: ACC_W] > best))) begin
        found = 1'b1;
        cand  = CW'(i);
        best  = stall_rate[i*ACC_W +: ACC_W];
      end
    end
    prev_rate = stall_rate[int'(prev)*ACC_W +: ACC_W];
    lhs       = PW'(best) * PW'(HYST_DEN);
    rhs       = PW'(prev_rate) * PW'(HYST_NUM);
    take_cand = !elig[prev] || (lhs > rhs);
    dest      = take_cand ? cand : prev;
  end
endmodule

// File: rtl/mig_arbiter.sv
module mig_arbiter
  import mig_pkg::*;
#(
  parameter int NCORE      = 4,
  parameter int NCTX       = 2,
  parameter int NTHR       = 16,
  parameter int SMP_W      = 8,
  parameter int ACC_W      = 24,
  parameter int WIN_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int HYST_NUM   = 21,
  parameter int HYST_DEN   = 20,
  localparam int CW        = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int TW        = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WIN_W-1:0]       cfg_window,
  input  logic [ACC_W-1:0]       cfg_conf_thr,
  input  logic [NCORE-1:0]       smp_valid,
  input  logic [NCORE*SMP_W-1:0] smp_conf,
  input  logic [NCORE*SMP_W-1:0] smp_stall,
  input  logic [NCORE*NCTX-1:0]  ctx_occ,
  input  logic                   ev_valid,
  input  logic                   ev_kind,
  input  logic [TW-1:0]          ev_thread,
  input  logic [CW-1:0]          ev_core,
  output logic                   cmd_valid,
  output logic                   cmd_kind,
  output logic [TW-1:0]          cmd_thread,
  output logic [CW-1:0]          cmd_core,
  input  logic                   cmd_done
);
  localparam int EW = 1 + TW + CW;

  logic [NCORE*ACC_W-1:0] conf_rate, stall_rate;
  logic [NCORE-1:0]       core_full, core_multi;

  mig_rate_track #(.NCORE(NCORE), .SMP_W(SMP_W), .ACC_W(ACC_W), .WIN_W(WIN_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .cfg_window(cfg_window), .smp_valid(smp_valid),
    .smp_conf(smp_conf), .smp_stall(smp_stall),
    .conf_rate(conf_rate), .stall_rate(stall_rate)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_occ
    always_comb begin
      int n;
      n = 0;
      for (int k = 0; k < NCTX; k++) n += int'(ctx_occ[c*NCTX + k]);
      core_full[c]  = (n >= NCTX);
      core_multi[c] = (n >= 2);
    end
  end

  // event queue
  logic [EW-1:0] q_dout;
  logic          q_empty, q_full, q_pop;

  mig_evt_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(ev_valid), .din({ev_kind, ev_thread, ev_core}),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  logic          hd_kind;
  logic [TW-1:0] hd_thr;
  logic [CW-1:0] hd_core;
  assign {hd_kind, hd_thr, hd_core} = q_dout;

  // parked-thread table
  logic [NTHR-1:0]         parked_q, parked_d;
  logic [NTHR-1:0][CW-1:0] home_q, home_d;

  // placement
  logic [NCORE-1:0] pl_elig;
  logic [CW-1:0]    pl_prev, pl_dest;
  logic             pl_found;

  mig_place #(.NCORE(NCORE), .ACC_W(ACC_W), .HYST_NUM(HYST_NUM), .HYST_DEN(HYST_DEN)) u_place (
    .stall_rate(stall_rate), .elig(pl_elig), .prev(pl_prev),
    .found(pl_found), .dest(pl_dest)
  );

  logic          cmd_valid_q, cmd_valid_d;
  logic          cmd_kind_q, cmd_kind_d;
  logic [TW-1:0] cmd_thr_q, cmd_thr_d;
  logic [CW-1:0] cmd_core_q, cmd_core_d;
  logic          go, is_stall, conf_hot, do_evict, do_disp, issue;

  always_comb begin
    is_stall = (hd_kind == EV_STALL);
    go       = !q_empty && !cmd_valid_q;
    pl_prev  = is_stall ? hd_core : home_q[hd_thr];
    pl_elig  = ~core_full | (is_stall ? (NCORE'(1) << hd_core) : '0);
    conf_hot = conf_rate[int'(hd_core)*ACC_W +: ACC_W] > cfg_conf_thr;
    do_evict = is_stall && !parked_q[hd_thr] && core_multi[hd_core] && conf_hot &&
               pl_found && (pl_dest != hd_core);
    do_disp  = !is_stall && parked_q[hd_thr] && pl_found;
    issue    = go && (do_evict || do_disp);
    q_pop    = go && !(!is_stall && parked_q[hd_thr] && !pl_found);

    parked_d    = parked_q;
    home_d      = home_q;
    cmd_valid_d = cmd_valid_q;
    cmd_kind_d  = cmd_kind_q;
    cmd_thr_d   = cmd_thr_q;
    cmd_core_d  = cmd_core_q;
    if (issue) begin
      cmd_valid_d = 1'b1;
      cmd_thr_d   = hd_thr;
      if (do_evict) begin
        cmd_kind_d       = CMD_EVICT;
        cmd_core_d       = hd_core;
        parked_d[hd_thr] = 1'b1;
        home_d[hd_thr]   = hd_core;
      end else begin
        cmd_kind_d       = CMD_DISPATCH;
        cmd_core_d       = pl_dest;
        parked_d[hd_thr] = 1'b0;
      end
    end else if (cmd_valid_q && cmd_done) begin
      cmd_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parked_q    <= '0;
      home_q      <= '0;
      cmd_valid_q <= 1'b0;
      cmd_kind_q  <= 1'b0;
      cmd_thr_q   <= '0;
      cmd_core_q  <= '0;
    end else begin
      parked_q    <= parked_d;
      home_q      <= home_d;
      cmd_valid_q <= cmd_valid_d;
      cmd_kind_q  <= cmd_kind_d;
      cmd_thr_q   <= cmd_thr_d;
      cmd_core_q  <= cmd_core_d;
    end
  end

  assign cmd_valid  = cmd_valid_q;
  assign cmd_kind   = cmd_kind_q;
  assign cmd_thread = cmd_thr_q;
  assign cmd_core   = cmd_core_q;

  // occupancy seen by the previous decision, for the checks below
  logic [NCORE-1:0] full_seen_q, multi_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_seen_q  <= '0;
      multi_seen_q <= '0;
    end else begin
      full_seen_q  <= core_full;
      multi_seen_q <= core_multi;
    end
  end

  // R9: an outstanding command is held unchanged until acknowledged
  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_q && !cmd_done) |=> (cmd_valid_q && $stable(cmd_kind_q) &&
                                    $stable(cmd_thr_q) && $stable(cmd_core_q)));
  // R7: a fresh dispatch never targets a core that was full when it was chosen
  a_r7_dest_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid_q) && cmd_kind_q == CMD_DISPATCH) |-> !full_seen_q[cmd_core_q]);
  // R3: an eviction only vacates a core that held at least two threads
  a_r3_evict_shared_core: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid_q) && cmd_kind_q == CMD_EVICT) |-> multi_seen_q[cmd_core_q]);
  // R8: a waiting completion is never dropped while no core is free
  a_r8_wait_at_head: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !is_stall && parked_q[hd_thr] && (&core_full)) |=> !q_empty);
endmodule

// File: tb/sim_mig_arbiter.sv
module sim_mig_arbiter;
  localparam int NC = 4, NT = 8, SW = 6, AW = 16, WW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic [WW-1:0]   cfg_window;
  logic [AW-1:0]   cfg_conf_thr;
  logic [NC-1:0]   smp_valid;
  logic [NC*SW-1:0] smp_conf, smp_stall;
  logic [NC*2-1:0] ctx_occ;
  logic            ev_valid, ev_kind, cmd_done;
  logic [2:0]      ev_thread;
  logic [1:0]      ev_core;
  logic            cmd_valid, cmd_kind;
  logic [2:0]      cmd_thread;
  logic [1:0]      cmd_core;

  mig_arbiter #(.NCORE(NC), .NCTX(2), .NTHR(NT), .SMP_W(SW), .ACC_W(AW),
                .WIN_W(WW), .FIFO_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_window(cfg_window), .cfg_conf_thr(cfg_conf_thr),
    .smp_valid(smp_valid), .smp_conf(smp_conf), .smp_stall(smp_stall),
    .ctx_occ(ctx_occ), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_thread(ev_thread),
    .ev_core(ev_core), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_thread(cmd_thread), .cmd_core(cmd_core), .cmd_done(cmd_done)
  );

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_rates(input int cf0, input int s0, input int s1, input int s2, input int s3);
    @(negedge clk);
    smp_conf            = '0;
    smp_conf[0 +: SW]   = SW'(cf0);
    smp_stall[0*SW +: SW] = SW'(s0);
    smp_stall[1*SW +: SW] = SW'(s1);
    smp_stall[2*SW +: SW] = SW'(s2);
    smp_stall[3*SW +: SW] = SW'(s3);
    repeat (14) @(negedge clk);
  endtask

  function automatic logic [1:0] occ_bits(input int n);
    return (n >= 2) ? 2'b11 : (n == 1) ? 2'b01 : 2'b00;
  endfunction

  task automatic set_occ(input int o0, input int o1, input int o2, input int o3);
    @(negedge clk);
    ctx_occ = {occ_bits(o3), occ_bits(o2), occ_bits(o1), occ_bits(o0)};
  endtask

  task automatic send(input bit k, input int t, input int c);
    @(negedge clk);
    ev_valid  = 1'b1;
    ev_kind   = k;
    ev_thread = 3'(t);
    ev_core   = 2'(c);
    @(negedge clk);
    ev_valid  = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic expect_cmd(input int k, input int t, input int c, input string tag);
    int act;
    repeat (2) @(negedge clk);
    check(cmd_valid == 1'b1, tag, int'(cmd_valid), 1);
    act = int'(cmd_kind) * 100 + int'(cmd_thread) * 10 + int'(cmd_core);
    check(act == k * 100 + t * 10 + c, tag, act, k * 100 + t * 10 + c);
    ack();
  endtask

  task automatic expect_none(input string tag);
    repeat (5) @(negedge clk);
    check(cmd_valid == 1'b0, tag, int'(cmd_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired before the run ended");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int act;
    rst_n = 1'b0; cfg_window = WW'(4); cfg_conf_thr = AW'(19);
    smp_valid = '1; smp_conf = '0; smp_stall = '0; ctx_occ = '0;
    ev_valid = 1'b0; ev_kind = 1'b0; ev_thread = '0; ev_core = '0; cmd_done = 1'b0;
    repeat (3) @(negedge clk);
    check(cmd_valid == 1'b0, "R11 in reset", int'(cmd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_valid == 1'b0, "R11 after reset", int'(cmd_valid), 0);

    // R3: lone thread stays put even with a hot core and a better destination
    set_occ(1, 0, 0, 0);
    set_rates(5, 0, 10, 0, 0);
    send(1'b0, 1, 0);
    expect_none("R3 lone thread not evicted");

    // R2: conflict count 20 against threshold 20 -> no eviction; 19 -> eviction
    set_occ(2, 0, 0, 0);
    @(negedge clk); cfg_conf_thr = AW'(20);
    send(1'b0, 1, 0);
    expect_none("R2 conflict equal to threshold");
    @(negedge clk); cfg_conf_thr = AW'(19);
    send(1'b0, 1, 0);
    expect_cmd(0, 1, 0, "R2 R12 evict above threshold");
    // R10: second stall of a parked thread ignored
    send(1'b0, 1, 0);
    expect_none("R10 stall of parked thread");
    send(1'b1, 1, 0);
    expect_cmd(1, 1, 1, "R6 R12 dispatch to stall-heavy core");
    // R10: completion for a thread never parked
    send(1'b1, 2, 0);
    expect_none("R10 completion of resident thread");

    // R6: tie among cores 1..3 -> lowest index
    set_rates(5, 0, 10, 10, 10);
    send(1'b0, 3, 0);
    expect_cmd(0, 3, 0, "R6 evict before tie");
    send(1'b1, 3, 0);
    expect_cmd(1, 3, 1, "R6 tie goes to lowest index");

    // R7: full core skipped
    set_occ(2, 2, 0, 0);
    send(1'b0, 4, 0);
    expect_cmd(0, 4, 0, "R7 evict with core1 full");
    send(1'b1, 4, 0);
    expect_cmd(1, 4, 2, "R7 full core never chosen");

    // R7: previous core full -> candidate without margin
    set_occ(2, 0, 0, 0);
    set_rates(5, 0, 30, 0, 0);
    send(1'b0, 5, 0);
    expect_cmd(0, 5, 0, "R7 evict setup");
    set_rates(5, 20, 21, 0, 0);
    send(1'b1, 5, 0);
    expect_cmd(1, 5, 1, "R7 previous core full");

    // R5: previous core free, candidate only 5% above -> back home
    set_rates(5, 0, 30, 0, 0);
    send(1'b0, 5, 0);
    expect_cmd(0, 5, 0, "R5 evict setup");
    set_rates(5, 20, 21, 0, 0);
    set_occ(1, 0, 0, 0);
    send(1'b1, 5, 0);
    expect_cmd(1, 5, 0, "R5 margin not met returns home");

    // R8: no free core -> wait, then dispatch when core3 frees
    set_occ(2, 0, 0, 0);
    set_rates(5, 0, 30, 0, 0);
    send(1'b0, 6, 0);
    expect_cmd(0, 6, 0, "R8 evict setup");
    set_occ(2, 2, 2, 2);
    send(1'b1, 6, 0);
    expect_none("R8 waits while all cores full");
    set_occ(2, 2, 2, 0);
    expect_cmd(1, 6, 3, "R8 dispatch once a context frees");

    // R9: two queued events, one command at a time, in order
    set_occ(2, 0, 0, 0);
    send(1'b0, 1, 0);
    send(1'b0, 7, 0);
    repeat (2) @(negedge clk);
    act = int'(cmd_valid) * 10 + int'(cmd_thread);
    check(act == 11, "R9 first command", act, 11);
    repeat (4) @(negedge clk);
    act = int'(cmd_valid) * 10 + int'(cmd_thread);
    check(act == 11, "R9 held until acknowledged", act, 11);
    ack();
    expect_cmd(0, 7, 0, "R9 second command after ack");
    send(1'b1, 7, 0);
    send(1'b1, 1, 0);
    expect_cmd(1, 7, 1, "R9 dispatch order first");
    expect_cmd(1, 1, 1, "R9 dispatch order second");

    // R4 R5 R1 sweep: home stall 20/sample, other core s/sample, window 4
    for (int s = 0; s < 32; s++) begin
      bit ev_exp;
      ev_exp = (s * 4 * 20) > (20 * 4 * 21);
      set_occ(2, 0, 2, 2);
      set_rates(5, 20, s, 0, 0);
      send(1'b0, 0, 0);
      if (ev_exp) begin
        expect_cmd(0, 0, 0, $sformatf("R4 R5 sweep evict s=%0d", s));
        set_occ(1, 0, 2, 2);
        send(1'b1, 0, 0);
        expect_cmd(1, 0, 1, $sformatf("R5 R1 sweep dispatch s=%0d", s));
      end else begin
        expect_none($sformatf("R4 R5 sweep suppressed s=%0d", s));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule